// File: doc/BRIEF.md
# Mesh Mailbox Message Queue

This block collects 64-bit messages that arrive as write transactions on a mesh-style packet interface and hands them to a host through a 32-bit register port. A mesh write whose destination address names this chip, the register page, the mesh register group and the mailbox low-word register is pushed onto an internal FIFO. The write's data field becomes the low word of the entry and its source-address field becomes the high word.

The host reads the low word of the oldest entry and then the high word. Only the high-word read removes the entry. A status register reports whether the queue holds entries, whether it is full, whether a message was lost because the queue was full, and how many entries are queued. An interrupt output stays high while at least one entry is waiting. Register reads answer one cycle after the request, together with a read-valid strobe.

Top module: `mesh_mailbox`

## Requirements
- R1: After reset the queue is empty, `mbox_irq` is low, `host_rvalid` is low and a status read returns 0.
- R2: A mesh transaction is pushed only when `mesh_valid` and `mesh_write` are both high and `mesh_dst` has bits [31:20] equal to the chip ID, bits [19:16] equal to 0xF, bits [10:8] equal to 7 and word index bits [7:2] equal to 0xC, which is offset 0x730. The entry's low word is `mesh_data` and its high word is `mesh_src`.
- R3: A mesh transaction that fails any single field of the R2 match, or that has `mesh_valid` or `mesh_write` low, leaves the queue unchanged.
- R4: The host registers sit in page 0xF, group 7. Offset 0x730 is the low word, 0x734 is the high word and 0x738 is status. Reading the low word leaves the queue unchanged. Reading the high word removes the oldest entry. Entries come out in arrival order.
- R5: `host_rvalid` is high exactly in the cycle after a cycle with `host_rd` high, and `host_rdata` holds the read result in that same cycle.
- R6: Reading the low or high word while the queue is empty returns 0. A high-word read while empty removes nothing.
- R7: The status word has bit 0 = not empty, bit 1 = full (count equals depth), bit 2 = overflow and bits [15:8] = entry count. All other bits read 0. A push into a full queue with no pop in the same cycle is dropped, and it sets overflow, which then holds.
- R8: A host write to status with data bit 2 set clears overflow. A status write with bit 2 clear leaves overflow set. A push dropped in the same cycle as the clear wins.
- R9: A push and a pop in the same cycle leave the count unchanged, even when the queue is full. In the full case the push is kept and overflow is not set.
- R10: `mbox_irq` is high exactly while the entry count is non-zero.
- R11: Reads at the same word offsets in the RX group 3 (0x730 to 0x738 become 0x330 to 0x338) return 0 and remove nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mesh_valid | input | 1 | Mesh transaction present |
| mesh_write | input | 1 | Mesh transaction is a write |
| mesh_dst | input | 32 | Mesh destination address |
| mesh_data | input | 32 | Mesh data field, stored as the low word |
| mesh_src | input | 32 | Mesh source-address field, stored as the high word |
| host_rd | input | 1 | Host register read request |
| host_wr | input | 1 | Host register write request |
| host_addr | input | 32 | Host register address; bits [31:20] are ignored |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read result strobe, one cycle after host_rd |
| mbox_irq | output | 1 | High while the queue is not empty |

## Verification
The bench builds the block with a depth of 4 and chip ID 0x810. A few pushes therefore fill the queue, which makes the full flag, dropped pushes, sticky overflow and push-with-pop at full all reachable in short directed scenarios. Because the scenarios run back to back on one instance, the read and write pointers wrap several times. The order checks therefore also cover slot reuse after wrap.

// File: rtl/mbx_pkg.sv
// Package: shared constants, register select type and status packing for
// the mesh mailbox. Assumes the page/group field positions are fixed at
// [19:16] and [10:8] of a 32-bit address.
package mbx_pkg;
    localparam logic [3:0] PAGE_REGS  = 4'hF;
    localparam logic [2:0] GROUP_MESH = 3'd7;
    localparam int         IDX_LO     = 12;
    localparam int         IDX_HI     = 13;
    localparam int         IDX_STAT   = 14;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_t;

    // Pack the status word from its fields.
    function automatic logic [31:0] pack_status(input logic [7:0] cnt,
                                                input logic ovf,
                                                input logic full,
                                                input logic not_empty);
        pack_status = {16'h0000, cnt, 5'b00000, ovf, full, not_empty};
    endfunction
endpackage

// File: rtl/mbx_decode.sv
// Module: mbx_decode
// Matches an address against the mailbox register set (page, mesh group,
// word index) and optionally the chip ID field. Purely combinational.
// Assumes RFAW >= 4 so that the word indices fit.
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          RFAW      = 6,
    parameter int          CHIP_ID_W = 12,
    parameter logic [CHIP_ID_W-1:0] CHIP_ID = '0,
    parameter bit          CHECK_ID  = 1'b1
) (
    input  logic [AW-1:0] addr,
    output reg_sel_t      sel
);
    logic id_ok;
    logic blk_ok;
    logic [RFAW-1:0] idx;

    generate
        if (CHECK_ID) begin : g_id
            assign id_ok = (addr[AW-1:AW-CHIP_ID_W] == CHIP_ID);
        end else begin : g_noid
            assign id_ok = 1'b1;
        end
    endgenerate

    assign blk_ok = (addr[19:16] == PAGE_REGS) && (addr[10:8] == GROUP_MESH);
    assign idx    = addr[RFAW+1:2];

    // Select which mailbox register the address hits.
    always_comb begin
        sel = SEL_NONE;
        if (id_ok && blk_ok) begin
            if (idx == RFAW'(IDX_LO))        sel = SEL_LO;
            else if (idx == RFAW'(IDX_HI))   sel = SEL_HI;
            else if (idx == RFAW'(IDX_STAT)) sel = SEL_STAT;
        end
    end
endmodule

// File: rtl/mbx_fifo.sv
// Module: mbx_fifo
// Entry storage with read/write pointers and an occupancy count. Gates
// the raw push/pop requests: pop only when not empty, push when not full
// or when a pop frees a slot in the same cycle. Any DEPTH >= 2 is allowed.
module mbx_fifo #(
    parameter int W     = 64,
    parameter int DEPTH = 16,
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push_req,
    input  logic            pop_req,
    input  logic [W-1:0]    wdata,
    output logic [W-1:0]    head,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            empty,
    output logic            push_ok,
    output logic            pop_ok
);
    logic [W-1:0]    mem [DEPTH];
    logic [PTRW-1:0] wr_ptr;
    logic [PTRW-1:0] rd_ptr;

    assign empty   = (count == '0);
    assign full    = (count == CNTW'(DEPTH));
    assign pop_ok  = pop_req && !empty;
    assign push_ok = push_req && (!full || pop_ok);
    assign head    = mem[rd_ptr];

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
        bump = (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Store the pushed entry.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Maintain pointers and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/mbx_regs.sv
// Module: mbx_regs
// Host-facing register logic: registered read data with a one-cycle valid
// strobe, pop request on high-word reads, and the sticky overflow flag.
// Assumes host reads and writes of status are not relied on together.
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int DW   = 32,
    parameter int CNTW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic            wr_req,
    input  reg_sel_t        sel,
    input  logic [DW-1:0]   wdata,
    input  logic [2*DW-1:0] head,
    input  logic [CNTW-1:0] count,
    input  logic            full,
    input  logic            empty,
    input  logic            drop,
    output logic            pop_req,
    output logic [DW-1:0]   rdata,
    output logic            rvalid,
    output logic            ovf
);
    logic [DW-1:0] rd_mux;
    logic          clr;

    assign pop_req = rd_req && (sel == SEL_HI);
    assign clr     = wr_req && (sel == SEL_STAT) && wdata[2];

    // Pick the read value for the addressed register.
    always_comb begin
        rd_mux = '0;
        case (sel)
            SEL_LO:   rd_mux = empty ? '0 : head[DW-1:0];
            SEL_HI:   rd_mux = empty ? '0 : head[2*DW-1:DW];
            SEL_STAT: rd_mux = DW'(pack_status(8'(count), ovf, full, !empty));
            default:  rd_mux = '0;
        endcase
    end

    // Register read data and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_req;
            if (rd_req) rdata <= rd_mux;
        end
    end

    // Sticky overflow: a drop sets it, and a write of 1 clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf <= 1'b0;
        else if (drop) ovf <= 1'b1;
        else if (clr)  ovf <= 1'b0;
    end
endmodule

// File: rtl/mesh_mailbox.sv
// Module: mesh_mailbox (top)
// Queues 64-bit messages from mesh writes aimed at the mailbox low-word
// register and serves them to a host over a 32-bit register port.
// Assumes DEPTH <= 255 so the count fits the 8-bit status field.
module mesh_mailbox
    import mbx_pkg::*;
#(
    parameter int CHIP_ID_W = 12,
    parameter logic [CHIP_ID_W-1:0] CHIP_ID = 12'h810,
    parameter int DEPTH     = 16,
    parameter int RFAW      = 6,
    parameter int AW        = 32,
    parameter int DW        = 32,
    localparam int CNTW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mesh_valid,
    input  logic          mesh_write,
    input  logic [AW-1:0] mesh_dst,
    input  logic [DW-1:0] mesh_data,
    input  logic [AW-1:0] mesh_src,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_rvalid,
    output logic          mbox_irq
);
    reg_sel_t          mesh_sel;
    reg_sel_t          host_sel;
    logic              push_hit;
    logic              pop_req;
    logic              push_ok;
    logic              pop_ok;
    logic              fifo_full;
    logic              fifo_empty;
    logic              drop;
    logic              ovf_flag;
    logic [2*DW-1:0]   head;
    logic [CNTW-1:0]   fifo_count;

    mbx_decode #(.AW(AW), .RFAW(RFAW), .CHIP_ID_W(CHIP_ID_W),
                 .CHIP_ID(CHIP_ID), .CHECK_ID(1'b1)) u_mesh_dec (
        .addr(mesh_dst), .sel(mesh_sel)
    );

    mbx_decode #(.AW(AW), .RFAW(RFAW), .CHIP_ID_W(CHIP_ID_W),
                 .CHIP_ID(CHIP_ID), .CHECK_ID(1'b0)) u_host_dec (
        .addr(host_addr), .sel(host_sel)
    );

    assign push_hit = mesh_valid && mesh_write && (mesh_sel == SEL_LO);
    assign drop     = push_hit && !push_ok;
    assign mbox_irq = !fifo_empty;

    mbx_fifo #(.W(2*DW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_req(push_hit), .pop_req(pop_req),
        .wdata({mesh_src, mesh_data}),
        .head(head), .count(fifo_count),
        .full(fifo_full), .empty(fifo_empty),
        .push_ok(push_ok), .pop_ok(pop_ok)
    );

    mbx_regs #(.DW(DW), .CNTW(CNTW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .rd_req(host_rd), .wr_req(host_wr), .sel(host_sel),
        .wdata(host_wdata), .head(head), .count(fifo_count),
        .full(fifo_full), .empty(fifo_empty), .drop(drop),
        .pop_req(pop_req), .rdata(host_rdata), .rvalid(host_rvalid),
        .ovf(ovf_flag)
    );
endmodule

// File: rtl/mbx_checker.sv
// Module: mbx_checker
// Temporal checks on the mailbox, bound into every mesh_mailbox instance.
module mbx_checker #(
    parameter int DEPTH = 16,
    parameter int RFAW  = 6,
    parameter int CNTW  = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            host_rd,
    input logic            host_wr,
    input logic [31:0]     host_addr,
    input logic [31:0]     host_wdata,
    input logic [31:0]     host_rdata,
    input logic            host_rvalid,
    input logic            mbox_irq,
    input logic [CNTW-1:0] cnt,
    input logic            push_ok,
    input logic            pop_ok,
    input logic            ovf
);
    logic in_mesh;
    logic is_lo;
    logic is_data;
    logic clr;

    assign in_mesh = (host_addr[19:16] == 4'hF) && (host_addr[10:8] == 3'd7);
    assign is_lo   = in_mesh && (host_addr[RFAW+1:2] == RFAW'(12));
    assign is_data = in_mesh && ((host_addr[RFAW+1:2] == RFAW'(12)) ||
                                 (host_addr[RFAW+1:2] == RFAW'(13)));
    assign clr     = host_wr && in_mesh && (host_addr[RFAW+1:2] == RFAW'(14)) &&
                     host_wdata[2];

    a_r5_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> host_rvalid);
    a_r5_rvalid_only: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> !host_rvalid);
    a_r6_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && is_data && !mbox_irq) |=> (host_rdata == 32'h0));
    a_r10_irq_after_push: assert property (@(posedge clk) disable iff (!rst_n)
        push_ok |=> mbox_irq);
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNTW'(DEPTH));
    a_r9_pushpop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push_ok && pop_ok) |=> (cnt == $past(cnt)));
    a_r4_lo_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && is_lo && !push_ok) |=> (cnt == $past(cnt)));
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clr) |=> ovf);
    a_r11_rx_group_nopop: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (host_addr[10:8] == 3'd3) && !push_ok) |=> (cnt == $past(cnt)));
endmodule

bind mesh_mailbox mbx_checker #(.DEPTH(DEPTH), .RFAW(RFAW), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .mbox_irq(mbox_irq), .cnt(fifo_count),
    .push_ok(push_ok), .pop_ok(pop_ok), .ovf(ovf_flag)
);

// File: tb/sim_mesh_mailbox.sv
// Directed bench for mesh_mailbox, built with DEPTH=4 and chip ID 0x810.
module sim_mesh_mailbox;
    localparam int PERIOD = 10;
    localparam int DEPTH  = 4;
    localparam logic [31:0] M_LO   = 32'h810F_0730;
    localparam logic [31:0] H_LO   = 32'h000F_0730;
    localparam logic [31:0] H_HI   = 32'h000F_0734;
    localparam logic [31:0] H_STAT = 32'h000F_0738;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mesh_valid = 1'b0, mesh_write = 1'b0;
    logic [31:0] mesh_dst = '0, mesh_data = '0, mesh_src = '0;
    logic        host_rd = 1'b0, host_wr = 1'b0;
    logic [31:0] host_addr = '0, host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid, mbox_irq;
    int          n_checks = 0;
    int          n_errors = 0;

    always #(PERIOD/2) clk = ~clk;

    mesh_mailbox #(.DEPTH(DEPTH), .CHIP_ID(12'h810)) u0 (
        .clk(clk), .rst_n(rst_n), .mesh_valid(mesh_valid), .mesh_write(mesh_write),
        .mesh_dst(mesh_dst), .mesh_data(mesh_data), .mesh_src(mesh_src),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .mbox_irq(mbox_irq)
    );

    function automatic logic [31:0] stat(input int cnt, input bit ovf);
        stat = {16'h0, 8'(cnt), 5'b0, ovf, (cnt == DEPTH), (cnt != 0)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input logic [31:0] dst, input logic [31:0] d, input logic [31:0] s,
                        input bit v = 1, input bit w = 1);
        mesh_valid = v; mesh_write = w; mesh_dst = dst; mesh_data = d; mesh_src = s;
        tick();
        mesh_valid = 0; mesh_write = 0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        host_rd = 1; host_addr = a;
        tick();
        host_rd = 0;
        check("R5 rvalid", {31'b0, host_rvalid}, 32'h1);
        d = host_rdata;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        host_wr = 1; host_addr = a; host_wdata = d;
        tick();
        host_wr = 0;
    endtask

    task automatic expect_rd(input string req, input logic [31:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    task automatic t_reset();
        check("R1 irq", {31'b0, mbox_irq}, 32'h0);
        check("R1 rvalid", {31'b0, host_rvalid}, 32'h0);
        expect_rd("R1 status", H_STAT, 32'h0);
    endtask

    task automatic t_basic();
        push(M_LO, 32'hA5A5_0001, 32'h5A5A_1001);
        check("R10 irq set", {31'b0, mbox_irq}, 32'h1);
        expect_rd("R2 status count", H_STAT, stat(1, 0));
        expect_rd("R2 low word", H_LO, 32'hA5A5_0001);
        expect_rd("R4 low read no pop", H_STAT, stat(1, 0));
        expect_rd("R2 high word", H_HI, 32'h5A5A_1001);
        check("R5 rvalid drop", {31'b0, host_rvalid}, 32'h1);
        tick();
        check("R5 rvalid single", {31'b0, host_rvalid}, 32'h0);
        check("R10 irq clear", {31'b0, mbox_irq}, 32'h0);
        expect_rd("R4 high read pops", H_STAT, stat(0, 0));
    endtask

    task automatic t_miss();
        push(32'h811F_0730, 1, 1);
        push(32'h810E_0730, 2, 2);
        push(32'h810F_0330, 3, 3);
        push(32'h810F_0734, 4, 4);
        push(M_LO, 5, 5, 1, 0);
        push(M_LO, 6, 6, 0, 1);
        expect_rd("R3 no push on miss", H_STAT, stat(0, 0));
    endtask

    task automatic t_order();
        for (int i = 0; i < 3; i++) push(M_LO, 32'h100 + i, 32'h200 + i);
        for (int i = 0; i < 3; i++) begin
            expect_rd("R4 order low", H_LO, 32'h100 + i);
            expect_rd("R4 order high", H_HI, 32'h200 + i);
        end
        expect_rd("R4 drained", H_STAT, stat(0, 0));
    endtask

    task automatic t_empty();
        expect_rd("R6 empty low", H_LO, 32'h0);
        expect_rd("R6 empty high", H_HI, 32'h0);
        expect_rd("R6 status", H_STAT, stat(0, 0));
        push(M_LO, 32'hCAFE_0000, 32'hBEEF_0000);
        expect_rd("R6 pointer kept", H_LO, 32'hCAFE_0000);
        expect_rd("R6 pointer kept hi", H_HI, 32'hBEEF_0000);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) push(M_LO, 32'h300 + i, 32'h400 + i);
        expect_rd("R7 full", H_STAT, stat(DEPTH, 0));
        push(M_LO, 32'hDEAD, 32'hDEAD);
        expect_rd("R7 overflow", H_STAT, stat(DEPTH, 1));
        for (int i = 0; i < DEPTH; i++) begin
            expect_rd("R7 kept low", H_LO, 32'h300 + i);
            expect_rd("R7 kept high", H_HI, 32'h400 + i);
        end
        expect_rd("R7 sticky", H_STAT, stat(0, 1));
    endtask

    task automatic t_clear();
        wr(H_STAT, 32'h0000_0003);
        expect_rd("R8 bit2 clear keeps", H_STAT, stat(0, 1));
        wr(H_STAT, 32'h0000_0004);
        expect_rd("R8 cleared", H_STAT, stat(0, 0));
    endtask

    task automatic pushpop(input logic [31:0] d, input logic [31:0] s, output logic [31:0] r);
        mesh_valid = 1; mesh_write = 1; mesh_dst = M_LO; mesh_data = d; mesh_src = s;
        host_rd = 1; host_addr = H_HI;
        tick();
        mesh_valid = 0; mesh_write = 0; host_rd = 0;
        r = host_rdata;
    endtask

    task automatic t_pushpop();
        logic [31:0] r;
        push(M_LO, 32'h500, 32'h600);
        pushpop(32'h501, 32'h601, r);
        check("R9 popped old", r, 32'h600);
        expect_rd("R9 count held", H_STAT, stat(1, 0));
        expect_rd("R9 new low", H_LO, 32'h501);
        expect_rd("R9 new high", H_HI, 32'h601);
        for (int i = 0; i < DEPTH; i++) push(M_LO, 32'h700 + i, 32'h800 + i);
        pushpop(32'h7FF, 32'h8FF, r);
        check("R9 full pop", r, 32'h800);
        expect_rd("R9 full held no ovf", H_STAT, stat(DEPTH, 0));
        for (int i = 1; i < DEPTH; i++) expect_rd("R9 drain", H_HI, 32'h800 + i);
        expect_rd("R9 full kept push", H_HI, 32'h8FF);
    endtask

    task automatic t_rxgroup();
        push(M_LO, 32'h900, 32'hA00);
        expect_rd("R11 rx low", 32'h000F_0330, 32'h0);
        expect_rd("R11 rx high", 32'h000F_0334, 32'h0);
        expect_rd("R11 rx stat", 32'h000F_0338, 32'h0);
        expect_rd("R11 no pop", H_STAT, stat(1, 0));
        expect_rd("R11 entry intact", H_HI, 32'hA00);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_basic();
        t_miss();
        t_order();
        t_empty();
        t_full();
        t_clear();
        t_pushpop();
        t_rxgroup();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(PERIOD * 20000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule